// File: doc/BRIEF.md
# DDR Self-Refresh Entry/Exit Sequencer

This block controls the clock-enable pin and the command bus of a DDR SDRAM while the memory is put into self-refresh and brought back out. A power manager asks for entry with `enter_req`. The sequencer then drives a self-refresh command in the same cycle that it pulls CKE low. While the memory is in self-refresh, CKE stays low and the command bus holds NOP.

When the power manager asks for exit with `exit_req`, the sequencer first waits for `clk_stable`. Only then does it raise CKE. After the rise it holds NOP for a short exit window. It then hands non-read commands back to the normal controller. It keeps the read-ready flag low until a longer lockout has run, which covers the time the memory's DLL needs to re-lock. After that it returns to idle.

Top module: `sr_sequencer`

## Requirements
- R1: While reset is asserted, `cke` is 0, `cmd` is NOP (2'b00), `busy` is 0 and `rd_ok` is 0. From the first rising clock edge after reset is released, the idle block drives `cke`=1, `cmd`=RELEASE (2'b10) and `rd_ok`=1.
- R2: An `enter_req` sampled high in idle is followed by exactly one cycle in which `cmd`=SREF (2'b01) while `cke`=0. That cycle is the first cycle in which `cke` is low.
- R3: Whenever `cke` is 0, outside the single entry cycle, `cmd` is NOP.
- R4: After an `exit_req` is accepted, `cke` stays 0 for as long as `clk_stable` is sampled low. `cke` rises in the cycle after the first edge that samples `clk_stable` high.
- R5: Counting the cycle in which `cke` rises as the first, `cmd` is NOP for XSNR_CYCLES cycles and is RELEASE from then on.
- R6: `rd_ok` stays 0 for NOP_CYCLES cycles starting with the cycle in which `cke` rises, and becomes 1 in the next cycle.
- R7: `busy` is 1 from the entry cycle until one cycle after `rd_ok` rises, and 0 in idle.
- R8: `enter_req` has an effect only in idle, and `exit_req` only in self-refresh. At any other time either request leaves `cke`, `cmd`, `busy` and `rd_ok` unchanged from the values they would otherwise have.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enter_req | input | 1 | Request to enter self-refresh |
| exit_req | input | 1 | Request to leave self-refresh |
| clk_stable | input | 1 | Memory clock is stable |
| cke | output | 1 | Memory clock enable |
| cmd | output | 2 | 00 NOP, 01 self-refresh entry, 10 released to controller |
| busy | output | 1 | Sequence in progress |
| rd_ok | output | 1 | Reads permitted |

## Verification
The bench runs full entry and exit sequences while it sweeps how long `clk_stable` is held low after the exit request. A design that raised CKE before the clock was stable would show a high `cke` during that delay. The bench checks every cycle of the post-exit window against the computed boundary between NOP and RELEASE, and against the exact cycle in which `rd_ok` rises. An off-by-one counter would therefore either release commands a cycle early or hold reads a cycle too long. The bench also keeps the requests that should be ignored asserted in the wrong states, so that a loose state decode would show up as a spurious exit or re-entry.

// File: rtl/sr_sequencer.sv
module sr_sequencer #(
  parameter int NOP_CYCLES  = 200,
  parameter int XSNR_CYCLES = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter_req,
  input  logic       exit_req,
  input  logic       clk_stable,
  output logic       cke,
  output logic [1:0] cmd,
  output logic       busy,
  output logic       rd_ok
);
  localparam int CW = $clog2(NOP_CYCLES + 1);
  localparam logic [1:0] C_NOP = 2'b00, C_SREF = 2'b01, C_REL = 2'b10;
  localparam logic [CW-1:0] LAST = CW'(NOP_CYCLES - 1);
  localparam logic [CW-1:0] XS   = CW'(XSNR_CYCLES);

  typedef enum logic [2:0] {IDLE, ENTER, IN_SR, WAIT_CLK, NOP_WIN, DONE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          up;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= IDLE;
      cnt <= '0;
      up  <= 1'b0;
    end else begin
      up <= 1'b1;
      case (st)
        IDLE:     if (enter_req) st <= ENTER;
        ENTER:    st <= IN_SR;
        IN_SR:    if (exit_req) st <= WAIT_CLK;
        WAIT_CLK: if (clk_stable) begin
                    st  <= NOP_WIN;
                    cnt <= '0;
                  end
        NOP_WIN:  if (cnt == LAST) st <= DONE;
                  else cnt <= cnt + 1'b1;
        DONE:     st <= IDLE;
        default:  st <= IDLE;
      endcase
    end
  end

  assign cke   = (st == IDLE) ? up : (st == NOP_WIN || st == DONE);
  assign busy  = (st != IDLE);
  assign rd_ok = (st == IDLE) ? up : (st == DONE);

  always_comb begin
    case (st)
      IDLE:    cmd = up ? C_REL : C_NOP;
      ENTER:   cmd = C_SREF;
      NOP_WIN: cmd = (cnt < XS) ? C_NOP : C_REL;
      DONE:    cmd = C_REL;
      default: cmd = C_NOP;
    endcase
  end
endmodule

module sr_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clk_stable,
  input logic       cke,
  input logic [1:0] cmd,
  input logic       busy,
  input logic       rd_ok
);
  // R2
  sref_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b01) |-> !cke);
  // R3
  nop_while_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && cmd != 2'b01) |-> (cmd == 2'b00));
  // R4
  stable_before_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cke) && $past(busy)) |-> $past(clk_stable));
  // R5
  nop_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cke) && $past(busy)) |-> (cmd == 2'b00));
  // R6
  no_read_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cke) && $past(busy)) |-> !rd_ok);
  // R7
  sref_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'b01) |-> busy);
endmodule

bind sr_sequencer sr_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clk_stable(clk_stable),
  .cke(cke), .cmd(cmd), .busy(busy), .rd_ok(rd_ok));

// File: tb/sr_sequencer_test.sv
module sr_sequencer_test;
  localparam int N = 12;
  localparam int X = 5;

  logic clk = 0, rst_n = 0, enter_req = 0, exit_req = 0, clk_stable = 0;
  logic cke, busy, rd_ok;
  logic [1:0] cmd;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sr_sequencer #(.NOP_CYCLES(N), .XSNR_CYCLES(X)) uut (
    .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .exit_req(exit_req),
    .clk_stable(clk_stable), .cke(cke), .cmd(cmd), .busy(busy), .rd_ok(rd_ok));

  task automatic chk(string r, logic ecke, logic [1:0] ecmd, logic ebusy, logic erd);
    checks++;
    if (cke !== ecke || cmd !== ecmd || busy !== ebusy || rd_ok !== erd) begin
      errors++;
      $display("FAIL %s: cke/cmd/busy/rd_ok got %b/%b/%b/%b expected %b/%b/%b/%b",
               r, cke, cmd, busy, rd_ok, ecke, ecmd, ebusy, erd);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cycle_run(int dly, bit noise);
    enter_req = 1;
    exit_req  = noise;
    step();
    enter_req = 0;
    chk("R2 entry", 0, 2'b01, 1, 0);
    step();
    chk("R3 in self-refresh", 0, 2'b00, 1, 0);
    enter_req = 1;
    step();
    enter_req = noise;
    exit_req  = 0;
    chk("R8 enter ignored in self-refresh", 0, 2'b00, 1, 0);
    clk_stable = 0;
    exit_req = 1;
    step();
    exit_req = noise;
    for (int d = 0; d < dly; d++) begin
      chk("R4 wait for clock", 0, 2'b00, 1, 0);
      step();
    end
    clk_stable = 1;
    step();
    for (int k = 0; k < N; k++) begin
      chk(k < X ? "R5 nop window" : "R5 released", 1, k < X ? 2'b00 : 2'b10, 1, 0);
      if (k == N - 1) chk("R6 read lockout end", 1, k < X ? 2'b00 : 2'b10, 1, 0);
      step();
    end
    chk("R6 read ready", 1, 2'b10, 1, 1);
    enter_req = 0;
    exit_req  = 0;
    step();
    chk("R7 back to idle", 1, 2'b10, 0, 1);
  endtask

  initial begin
    #20000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got hung expected finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step();
    chk("R1 reset", 0, 2'b00, 0, 0);
    rst_n = 1;
    step();
    chk("R1 idle after reset", 1, 2'b10, 0, 1);
    exit_req = 1;
    step();
    exit_req = 0;
    chk("R8 exit ignored in idle", 1, 2'b10, 0, 1);
    for (int dly = 0; dly < 4; dly++) begin
      cycle_run(dly, 0);
      cycle_run(dly, 1);
    end
    step();
    chk("R7 idle stays idle", 1, 2'b10, 0, 1);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule